// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is the slave side of a three-wire serial memory link. The host selects it with a chip select, clocks it with a serial clock and sends it a serial data input. The block returns data on a serial output, driven through a data/enable pair so that a pad can release it to high impedance. A register array inside the block holds the contents, which survive the reset input. A configuration input chooses between 16-bit and 8-bit words over the same storage, so the array holds either 512 words or 1024 bytes by default.

All serial inputs are sampled by a fast system clock, and SK edges are found by comparing each sample with the one before. A command is a start bit, an opcode and an address. Write-type commands also carry data. Commands that change the array are held until chip select falls. They then run as a self-timed program cycle lasting `PROG_CYCLES` system clocks, and no serial clock is needed while it runs. The host polls the output to learn when the cycle is over.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While reset is low, do_en_o is 0. Reset leaves programming disabled, and the array contents are not changed by reset.
- R2: A command is a 1 start bit followed by a 2-bit opcode: 10 read, 01 write, 11 erase, 00 special. The address follows, 10 bits when org_i=1 (16-bit words) and 11 bits when org_i=0 (bytes). All bits are taken MSB first on SK rising edges. The address MSB is ignored.
- R3: After a read command, the SK rise that takes the last address bit drives DO with a 0. Each later SK rise then presents the next bit of the addressed word, MSB first.
- R4: While CS stays high, a read continues into the next address with no extra 0 bit, and wraps from the last address to address 0.
- R5: A write carries 16 data bits (org_i=1) or 8 data bits (org_i=0). It programs nothing until CS falls. The target is then replaced, with no prior erase needed, once PROG_CYCLES clocks have passed.
- R6: Erase sets one location to all ones. Special code 10 (the 2 bits after opcode 00, at the top of the address field) sets the whole array to all ones. Special code 01 is followed by a data field and writes it to every location.
- R7: With org_i=0, byte address b maps to word b>>1. An even b selects bits 15:8 and an odd b selects bits 7:0.
- R8: Once a program cycle has started, raising CS drives DO with 0 while the cycle runs and with 1 after it ends.
- R9: During status display, a 1 clocked in on DI releases DO on the next SK falling edge, and not before.
- R10: Special code 11 enables programming and special code 00 disables it. While programming is disabled, write, erase and both whole-array commands change nothing and start no program cycle.
- R11: CS going low before a command is complete discards it, and the next start bit begins a new command.
- R12: A command sent while a program cycle is running is ignored.
- R13: DO is released while CS is low, and while CS is high with no read or status in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| org_i | input | 1 | 1: 16-bit words, 0: bytes |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_en_o | output | 1 | Serial data out drive enable |

## Verification
The assertions check, on every cycle, that a program cycle starts only on a CS fall while programming is enabled. They also check that busy holds until the count ends, that DO reads 0 whenever it is driven during busy, and that a read opens with a 0 bit. Address wrap, the release of the reader on deselect and the blocking of start bits during busy are checked on every cycle too. Whether the right data reaches the right location can only be shown by the bench scenarios, which compare each read against a behavioural memory model. The same goes for the byte lane mapping, the partial-command aborts, and ignored commands leaving the contents untouched.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    EX_LOCK   = 2'b00,
    EX_FILL   = 2'b01,
    EX_CLEAR  = 2'b10,
    EX_UNLOCK = 2'b11
  } ext_e;

  typedef enum logic [2:0] {
    PG_NONE,
    PG_WORD,
    PG_ERASE,
    PG_ERASE_ALL,
    PG_FILL_ALL
  } prog_e;
endpackage

// File: rtl/mw_edge_sense.sv
module mw_edge_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  output logic sk_rise_o,
  output logic sk_fall_o,
  output logic cs_fall_o
);
  logic sk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
      cs_q <= cs_i;
    end
  end

  assign sk_rise_o = sk_i & ~sk_q;
  assign sk_fall_o = ~sk_i & sk_q;
  assign cs_fall_o = ~cs_i & cs_q;
endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_eeprom_pkg::*;
#(
  parameter int AW16 = 9,
  parameter int AW8  = AW16 + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            org_i,
  input  logic            cs_i,
  input  logic            sk_rise_i,
  input  logic            di_i,
  input  logic            busy_i,
  input  logic            wr_en_i,
  output logic            rd_start_o,
  output logic [AW8-1:0]  rd_addr_o,
  output logic            unlock_o,
  output logic            lock_o,
  output logic            armed_o,
  output prog_e           prog_o,
  output logic [AW8-1:0]  addr_o,
  output logic [15:0]     data_o
);
  localparam int AF16 = AW16 + 1;
  localparam int AF8  = AW8 + 1;
  localparam int HW   = AF8 + 2;
  localparam int CW   = $clog2((HW > 16 ? HW : 16) + 1);

  typedef enum logic [2:0] {D_IDLE, D_HDR, D_DATA, D_ARMED, D_SKIP} dstate_e;

  dstate_e         state_q;
  logic [HW-1:0]   hdr_q, hdr_nx;
  logic [CW-1:0]   cnt_q, hdr_last, dat_last;
  logic [15:0]     dat_q;
  logic [AW8-1:0]  addr_q, addr_nx;
  prog_e           prog_q;
  op_e             op;
  ext_e            ext;
  logic            hdr_done;

  always_comb begin
    hdr_nx   = {hdr_q[HW-2:0], di_i};
    hdr_last = org_i ? CW'(AF16 + 1) : CW'(AF8 + 1);
    dat_last = org_i ? CW'(15) : CW'(7);
    op       = org_i ? op_e'(hdr_nx[AF16 +: 2]) : op_e'(hdr_nx[AF8 +: 2]);
    ext      = org_i ? ext_e'(hdr_nx[AF16-2 +: 2]) : ext_e'(hdr_nx[AF8-2 +: 2]);
    addr_nx  = org_i ? {1'b0, hdr_nx[AW16-1:0]} : hdr_nx[AW8-1:0];
    hdr_done = (state_q == D_HDR) && cs_i && sk_rise_i && (cnt_q == hdr_last);
  end

  assign rd_start_o = hdr_done && (op == OP_READ);
  assign rd_addr_o  = addr_nx;
  assign unlock_o   = hdr_done && (op == OP_EXT) && (ext == EX_UNLOCK);
  assign lock_o     = hdr_done && (op == OP_EXT) && (ext == EX_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= D_IDLE;
      hdr_q   <= '0;
      cnt_q   <= '0;
      dat_q   <= '0;
      addr_q  <= '0;
      prog_q  <= PG_NONE;
    end else if (!cs_i) begin
      state_q <= D_IDLE;  // deselect discards any partial command
    end else if (sk_rise_i) begin
      unique case (state_q)
        D_IDLE: if (di_i && !busy_i) begin
          state_q <= D_HDR;
          cnt_q   <= '0;
          hdr_q   <= '0;
        end
        D_HDR: begin
          hdr_q <= hdr_nx;
          cnt_q <= cnt_q + 1'b1;
          if (hdr_done) begin
            addr_q  <= addr_nx;
            cnt_q   <= '0;
            dat_q   <= '0;
            prog_q  <= PG_NONE;
            state_q <= D_SKIP;
            unique case (op)
              OP_READ: ;
              OP_WRITE: if (wr_en_i) begin
                prog_q  <= PG_WORD;
                state_q <= D_DATA;
              end
              OP_ERASE: if (wr_en_i) begin
                prog_q  <= PG_ERASE;
                state_q <= D_ARMED;
              end
              default: begin
                if (ext == EX_CLEAR && wr_en_i) begin
                  prog_q  <= PG_ERASE_ALL;
                  state_q <= D_ARMED;
                end else if (ext == EX_FILL && wr_en_i) begin
                  prog_q  <= PG_FILL_ALL;
                  state_q <= D_DATA;
                end
              end
            endcase
          end
        end
        D_DATA: begin
          dat_q <= {dat_q[14:0], di_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == dat_last) state_q <= D_ARMED;
        end
        default: ;
      endcase
    end
  end

  assign armed_o = (state_q == D_ARMED);
  assign prog_o  = prog_q;
  assign addr_o  = addr_q;
  assign data_o  = dat_q;

  p_busy_blocks_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == D_IDLE && busy_i) |=> (state_q == D_IDLE));
endmodule

// File: rtl/mw_read_stream.sv
module mw_read_stream #(
  parameter int AW8 = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           org_i,
  input  logic           cs_i,
  input  logic           sk_rise_i,
  input  logic           start_i,
  input  logic [AW8-1:0] start_addr_i,
  input  logic [15:0]    fetch_data_i,
  output logic [AW8-1:0] fetch_addr_o,
  output logic           active_o,
  output logic           bit_o
);
  localparam logic [AW8-1:0] MASK8  = '1;
  localparam logic [AW8-1:0] MASK16 = MASK8 >> 1;

  logic           active_q, bit_q;
  logic [AW8-1:0] addr_q, mask, nxt;
  logic [15:0]    sh_q;
  logic [4:0]     left_q, len;

  assign mask         = org_i ? MASK16 : MASK8;
  assign len          = org_i ? 5'd16 : 5'd8;
  assign nxt          = (addr_q + 1'b1) & mask;
  assign fetch_addr_o = start_i ? (start_addr_i & mask) : nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bit_q    <= 1'b0;
      addr_q   <= '0;
      sh_q     <= '0;
      left_q   <= '0;
    end else if (!cs_i) begin
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      bit_q    <= 1'b0;  // leading zero before the first word only
      sh_q     <= fetch_data_i;
      left_q   <= len;
      addr_q   <= start_addr_i & mask;
    end else if (active_q && sk_rise_i) begin
      bit_q <= sh_q[15];
      if (left_q == 5'd1) begin
        addr_q <= nxt;
        sh_q   <= fetch_data_i;
        left_q <= len;
      end else begin
        sh_q   <= {sh_q[14:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign bit_o    = bit_q;

  p_dummy_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> !bit_q);

  p_wrap_to_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cs_i && !start_i && sk_rise_i && left_q == 5'd1 && addr_q == mask)
      |=> (addr_q == '0));
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_busy_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_eeprom_pkg::*;
#(
  parameter int WORDS       = 512,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic org_i,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_en_o
);
  localparam int AW16 = $clog2(WORDS);
  localparam int AW8  = AW16 + 1;

  logic            sk_rise, sk_fall, cs_fall;
  logic            rd_start, unlock, lock, armed;
  logic [AW8-1:0]  rd_addr, cmd_addr, fetch_addr;
  logic [15:0]     cmd_data, fetch_data;
  prog_e           cmd_prog;
  logic            busy, done, prog_start;
  logic            rd_active, rd_bit;
  logic            wr_en_q, stat_q, hz_q;

  prog_e           pg_op_q;
  logic [AW8-1:0]  pg_addr_q;
  logic [15:0]     pg_data_q;
  logic            pg_org_q;

  logic [15:0]     mem_q [WORDS];

  mw_edge_sense u_edge (
    .clk_i, .rst_ni, .cs_i, .sk_i,
    .sk_rise_o(sk_rise), .sk_fall_o(sk_fall), .cs_fall_o(cs_fall)
  );

  mw_cmd_decoder #(.AW16(AW16), .AW8(AW8)) u_dec (
    .clk_i, .rst_ni, .org_i, .cs_i,
    .sk_rise_i(sk_rise), .di_i, .busy_i(busy), .wr_en_i(wr_en_q),
    .rd_start_o(rd_start), .rd_addr_o(rd_addr),
    .unlock_o(unlock), .lock_o(lock), .armed_o(armed),
    .prog_o(cmd_prog), .addr_o(cmd_addr), .data_o(cmd_data)
  );

  mw_read_stream #(.AW8(AW8)) u_rd (
    .clk_i, .rst_ni, .org_i, .cs_i,
    .sk_rise_i(sk_rise), .start_i(rd_start), .start_addr_i(rd_addr),
    .fetch_data_i(fetch_data), .fetch_addr_o(fetch_addr),
    .active_o(rd_active), .bit_o(rd_bit)
  );

  assign prog_start = cs_fall && armed && !busy;

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .start_i(prog_start), .busy_o(busy), .done_o(done)
  );

  // fetch path, MSB-aligned for bytes; even byte address is the upper half
  logic [AW16-1:0] f_idx;
  logic [15:0]     f_word;
  always_comb begin
    f_idx      = org_i ? fetch_addr[AW16-1:0] : fetch_addr[AW8-1:1];
    f_word     = mem_q[f_idx];
    fetch_data = org_i ? f_word
                       : {(fetch_addr[0] ? f_word[7:0] : f_word[15:8]), 8'h00};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= 1'b0;
      pg_op_q   <= PG_NONE;
      pg_addr_q <= '0;
      pg_data_q <= '0;
      pg_org_q  <= 1'b1;
    end else begin
      if (unlock)    wr_en_q <= 1'b1;
      else if (lock) wr_en_q <= 1'b0;
      if (prog_start) begin
        pg_op_q   <= cmd_prog;
        pg_addr_q <= cmd_addr;
        pg_data_q <= cmd_data;
        pg_org_q  <= org_i;
      end
    end
  end

  // status display and its release by a clocked-in 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      hz_q   <= 1'b0;
    end else if (prog_start) begin
      stat_q <= 1'b1;
      hz_q   <= 1'b0;
    end else if (!cs_i) begin
      hz_q <= 1'b0;
    end else if (sk_fall && hz_q) begin
      stat_q <= 1'b0;
      hz_q   <= 1'b0;
    end else if (sk_rise && di_i && stat_q) begin
      hz_q <= 1'b1;
    end
  end

  // commit at the end of the self-timed cycle
  logic [AW16-1:0] w_idx;
  logic [15:0]     w_cur, w_new, fill;
  logic [7:0]      b_src;
  always_comb begin
    w_idx = pg_org_q ? pg_addr_q[AW16-1:0] : pg_addr_q[AW8-1:1];
    w_cur = mem_q[w_idx];
    b_src = (pg_op_q == PG_ERASE) ? 8'hFF : pg_data_q[7:0];
    fill  = pg_org_q ? pg_data_q : {pg_data_q[7:0], pg_data_q[7:0]};
    if (pg_org_q)
      w_new = (pg_op_q == PG_ERASE) ? 16'hFFFF : pg_data_q;
    else if (pg_addr_q[0])
      w_new = {w_cur[15:8], b_src};
    else
      w_new = {b_src, w_cur[7:0]};
  end

  always_ff @(posedge clk_i) begin
    if (done) begin
      unique case (pg_op_q)
        PG_WORD, PG_ERASE: mem_q[w_idx] <= w_new;
        PG_ERASE_ALL: for (int i = 0; i < WORDS; i++) mem_q[i] <= 16'hFFFF;
        PG_FILL_ALL:  for (int i = 0; i < WORDS; i++) mem_q[i] <= fill;
        default: ;
      endcase
    end
  end

  assign do_en_o = cs_i && (rd_active || stat_q);
  assign do_o    = rd_active ? rd_bit : !busy;

  p_release_on_deselect_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_i) |=> !rd_active);

  p_prog_needs_unlock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> wr_en_q);

  p_prog_on_deselect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(cs_i));

  p_busy_reads_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && do_en_o) |-> !do_o);
endmodule

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  localparam int PROG = 400;

  logic clk = 1'b0, rst_n = 1'b0, org = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_en;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;
  logic smp_do, smp_en;
  logic [15:0] mm [512];
  bit   m_en = 0;

  always #4 clk = ~clk;

  mw_eeprom_slave #(.WORDS(512), .PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .org_i(org), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_o), .do_en_o(do_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int eff(input int a);
    return org ? (a & 511) : (a & 1023);
  endfunction

  function automatic logic [15:0] m_get(input int a);
    int e = eff(a);
    if (org) return mm[e];
    return (e % 2 == 1) ? {8'h00, mm[e/2][7:0]} : {8'h00, mm[e/2][15:8]};
  endfunction

  task automatic m_put(input int a, input logic [15:0] d);
    int e = eff(a);
    if (org) mm[e] = d;
    else if (e % 2 == 1) mm[e/2][7:0] = d[7:0];
    else mm[e/2][15:8] = d[7:0];
  endtask

  task automatic sk_bit(input logic b);
    @(negedge clk); di = b;
    @(negedge clk); sk = 1'b1;
    @(negedge clk);
    @(negedge clk); smp_do = do_o; smp_en = do_en; sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_up;
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic cs_dn;
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_prog;
    repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input int a);
    cs_up;
    sk_bit(1'b1);
    send({30'd0, op}, 2);
    send(a, org ? 10 : 11);
  endtask

  task automatic ext(input logic [1:0] code);
    issue(2'b00, org ? (int'(code) << 8) : (int'(code) << 9));
  endtask

  task automatic unlock; ext(2'b11); cs_dn; m_en = 1; endtask
  task automatic lock;   ext(2'b00); cs_dn; m_en = 0; endtask

  task automatic do_write(input int a, input logic [15:0] d);
    issue(2'b01, a);
    send(d, org ? 16 : 8);
    cs_dn;
    if (m_en) m_put(a, d);
    wait_prog;
  endtask

  task automatic do_erase(input int a);
    issue(2'b11, a);
    cs_dn;
    if (m_en) m_put(a, 16'hFFFF);
    wait_prog;
  endtask

  task automatic rd_chk(input int a, input int n, input string req);
    int cur = eff(a);
    issue(2'b10, a);
    chk({req, " leading zero"}, {smp_en, smp_do}, 2'b10);
    for (int w = 0; w < n; w++) begin
      logic [15:0] got = '0;
      for (int i = 0; i < (org ? 16 : 8); i++) begin
        sk_bit(1'b0);
        got = {got[14:0], smp_do};
      end
      chk(req, got, m_get(cur));
      cur = eff(cur + 1);
    end
    cs_dn;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 DO released in reset", do_en, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // erase-all with status polling
    unlock;
    ext(2'b10);
    cs_dn;
    for (int i = 0; i < 512; i++) mm[i] = 16'hFFFF;
    cs_up;
    chk("R8 busy shown as 0", {do_en, do_o}, 2'b10);
    wait_prog;
    chk("R8 ready shown as 1", {do_en, do_o}, 2'b11);
    sk_bit(1'b1);
    chk("R9 still driven before SK fall", {smp_en, smp_do}, 2'b11);
    chk("R9 released after SK fall", do_en, 1'b0);
    cs_dn;
    rd_chk(3, 1, "R6 erase-all");

    do_write(3, 16'hA5C3);
    do_write(511, 16'h1234);
    do_write(0, 16'h0F0F);
    rd_chk(3, 1, "R5 write replaces word");
    rd_chk(511, 2, "R4 sequential wrap");
    do_write(32'h207, 16'h7777);
    rd_chk(7, 1, "R2 address MSB ignored");
    do_erase(3);
    rd_chk(3, 1, "R6 single erase");

    org = 1'b0;
    do_write(6, 16'h005A);
    rd_chk(1023, 2, "R7 byte wrap");
    rd_chk(6, 1, "R7 byte read");
    org = 1'b1;
    rd_chk(3, 1, "R7 even byte is upper half");

    // command during busy
    issue(2'b01, 20);
    send(16'h1111, 16);
    cs_dn;
    m_put(20, 16'h1111);
    cs_up;
    chk("R12 busy status", {do_en, do_o}, 2'b10);
    sk_bit(1'b1);
    send(32'b01, 2);
    send(21, 10);
    send(16'h2222, 16);
    cs_dn;
    wait_prog;
    rd_chk(21, 1, "R12 command ignored while busy");
    rd_chk(20, 1, "R12 running write completes");

    issue(2'b00, 32'h100);
    send(16'hBEEF, 16);
    cs_dn;
    for (int i = 0; i < 512; i++) mm[i] = 16'hBEEF;
    wait_prog;
    rd_chk(100, 1, "R6 write-all");

    lock;
    do_write(100, 16'h0000);
    cs_up;
    chk("R10 no cycle when disabled", do_en, 1'b0);
    cs_dn;
    rd_chk(100, 1, "R10 disabled write ignored");

    unlock;
    issue(2'b01, 30);
    send(32'h0, 15);
    cs_dn;
    cs_up;
    chk("R11 no cycle after abort", do_en, 1'b0);
    cs_dn;
    rd_chk(30, 1, "R11 aborted write discarded");
    cs_up;
    sk_bit(1'b1);
    sk_bit(1'b1);
    cs_dn;
    rd_chk(31, 1, "R11 fresh command after abort");

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_en = 0;
    @(negedge clk);
    do_write(100, 16'h0000);
    rd_chk(100, 1, "R1 disabled after reset");
    cs_up;
    chk("R13 released when idle", do_en, 1'b0);
    cs_dn;

    finished = 1;
    summary;
    $finish;
  end
endmodule